// File: doc/BRIEF.md
# External Interrupt Request Sense and Status Unit

This block sits between sixteen external interrupt request pins and a parent interrupt controller. Each pin is synchronised into the block clock domain. It is then sensed according to a per-pin mode: active-low level, falling edge, rising edge, or either edge. The result is held in a status flag. Each flag drives a level-high request line to the parent controller.

Software reaches the block through a plain 32-bit register port with an address, write data, a write strobe and combinational read data. This port has no stream interface, so no valid/ready handshake or back-pressure applies. The port maps three words:

| Offset | Register | Access |
|---|---|---|
| 0x10 | Flag status | Read |
| 0x14 | Edge flag clear | Write 1 to clear; reads as zero |
| 0x18 | Sense mode select | Read and write |

Latched edge flags stay set until software writes a 1 to the matching bit of the clear word. Level flags follow the pin and ignore the clear word.

Top module: `ext_irq_sense`

## Requirements
- R1: Each of the 16 pins passes through a two-flop synchroniser. A pin change first shows in the status flag 3 clock edges after it is applied, and not after only 2.
- R2: The sense mode register at offset 0x18 holds a 2-bit field for pin n at bits [2n+1:2n]. A write stores the word, and a read returns it.
- R3: Mode 0 is low level. In this mode the flag is 1 while the synchronised pin is low, and it returns to 0 by itself once the pin goes high.
- R4: The edge modes are 1 (falling), 2 (rising) and 3 (both). A matching edge sets the flag. The flag then stays set whatever the pin does until it is cleared.
- R5: Writing a 1 to bit n at offset 0x14 clears pin n's flag when pin n is in an edge mode. Bits written as 0 leave their flags untouched.
- R6: When a pin is in low-level mode, a clear write to its bit has no effect on its flag.
- R7: If a matching edge and a clear write for the same pin act in the same cycle, the flag ends up set.
- R8: A write to the mode register discards any edge pending in that cycle, so no flag is set by it. A write that changes a pin's field also resets that pin's flag to 0.
- R9: Output irq_out[n] equals flag n. A read at 0x10 returns the flags in bits [15:0] with zeros above them. Reads at 0x14 and at unmapped offsets return 0.
- R10: After reset all flags and mode fields are 0. The synchroniser flops reset to 1, so a low-level pin does not report a request before a real sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 16 | Raw external request pins, asynchronous |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 16 | Level-high requests to the parent controller |

## Verification
The assertions check four things on every cycle for every pin:
- latched edge flags hold without a clear;
- a clear with no competing edge empties a flag;
- an edge beats a simultaneous clear;
- a level-mode flag ignores clears while the pin is low.

They also check that a mode write lands in the mode register. The bench scenarios are needed for the rest:
- the exact three-edge latency through the synchroniser;
- the sense of each of the four modes;
- the discarding of an edge that coincides with a mode write;
- the read decoding of all offsets.

// File: rtl/ext_irq_sense_pkg.sv
package ext_irq_sense_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH = 16,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {WIDTH{RST_VAL}};
      q      <= {WIDTH{RST_VAL}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_sense_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_in,
  input  logic [MODE_W-1:0] mode,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_new,
  input  logic              clr,
  output logic              flag
);
  logic   prev;
  logic   rise, fall, edge_hit, edge_mode;
  logic   flag_nxt;
  sense_e sense;

  assign sense     = sense_e'(mode);
  assign edge_mode = (sense != SENSE_LOW);
  assign rise      = s_in & ~prev;
  assign fall      = ~s_in & prev;

  always_comb begin
    unique case (sense)
      SENSE_FALL: edge_hit = fall;
      SENSE_RISE: edge_hit = rise;
      SENSE_BOTH: edge_hit = rise | fall;
      default:    edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (mode_wr && (mode_new != mode))
      flag_nxt = 1'b0;
    else if (!edge_mode)
      flag_nxt = ~s_in;
    else
      flag_nxt = (edge_hit & ~mode_wr) | (flag & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b1;
      flag <= 1'b0;
    end else begin
      prev <= s_in;
      flag <= flag_nxt;
    end
  end

  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && flag && !clr && !mode_wr) |=> flag);

  assert_edge_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr && !edge_hit && !mode_wr) |=> !flag);

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && edge_hit && clr && !mode_wr) |=> flag);

  assert_level_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && clr && !s_in && !mode_wr) |=> flag);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_sense_pkg::*;
#(
  parameter int unsigned N_PINS   = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAT_OFS = 'h10,
  parameter int unsigned CLR_OFS  = 'h14,
  parameter int unsigned TYPE_OFS = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] irq_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_PINS-1:0] irq_out
);
  localparam int unsigned TYPE_W = N_PINS * MODE_W;

  logic [N_PINS-1:0] pin_s;
  logic [N_PINS-1:0] flags;
  logic [TYPE_W-1:0] type_q;
  logic              type_wr, clr_wr;

  assign type_wr = bus_wr && (bus_addr == ADDR_W'(TYPE_OFS));
  assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(CLR_OFS));

  ext_irq_sync #(.WIDTH(N_PINS), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_pin),
    .q     (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      type_q <= '0;
    else if (type_wr)
      type_q <= bus_wdata[TYPE_W-1:0];
  end

  for (genvar n = 0; n < N_PINS; n++) begin : g_chan
    ext_irq_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_in     (pin_s[n]),
      .mode     (type_q[MODE_W*n +: MODE_W]),
      .mode_wr  (type_wr),
      .mode_new (bus_wdata[MODE_W*n +: MODE_W]),
      .clr      (clr_wr & bus_wdata[n]),
      .flag     (flags[n])
    );
  end

  assign irq_out = flags;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(STAT_OFS))
      bus_rdata[N_PINS-1:0] = flags;
    else if (bus_addr == ADDR_W'(TYPE_OFS))
      bus_rdata[TYPE_W-1:0] = type_q;
  end

  assert_type_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    type_wr |=> type_q == $past(bus_wdata[TYPE_W-1:0]));
endmodule

// File: tb/ext_irq_sense_bench.sv
`timescale 1ns/1ps
module ext_irq_sense_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_pin = 16'hFFFF;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_STAT = 8'h10, A_CLR = 8'h14, A_TYPE = 8'h18;

  always #4 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d); check("R10 status after reset", d, 32'h0);
    rd(A_TYPE, d); check("R10 type after reset", d, 32'h0);
    check("R10 irq_out after reset", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic t_type_rw();
    logic [31:0] d;
    wr(A_TYPE, 32'h5555_00E4);
    rd(A_TYPE, d); check("R2 type readback", d, 32'h5555_00E4);
  endtask

  task automatic t_level();
    logic [31:0] d;
    irq_pin[0] = 1'b0; settle();
    rd(A_STAT, d); check("R3 level low sets flag", d & 32'h1, 32'h1);
    wr(A_CLR, 32'h1);
    rd(A_STAT, d); check("R6 clear ignored in level mode", d & 32'h1, 32'h1);
    irq_pin[0] = 1'b1; settle();
    rd(A_STAT, d); check("R3 level flag self clears", d & 32'h1, 32'h0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    irq_pin[1] = 1'b0; settle();
    rd(A_STAT, d); check("R4 falling edge sets", d & 32'h2, 32'h2);
    irq_pin[1] = 1'b1; settle();
    rd(A_STAT, d); check("R4 falling flag latched", d & 32'h2, 32'h2);
    irq_pin[2] = 1'b0; settle();
    rd(A_STAT, d); check("R4 rising ignores fall", d & 32'h4, 32'h0);
    irq_pin[2] = 1'b1; settle();
    rd(A_STAT, d); check("R4 rising edge sets", d & 32'h4, 32'h4);
    irq_pin[3] = 1'b0; settle();
    rd(A_STAT, d); check("R4 both mode fall sets", d & 32'h8, 32'h8);
    wr(A_CLR, 32'h8);
    irq_pin[3] = 1'b1; settle();
    rd(A_STAT, d); check("R4 both mode rise sets", d & 32'h8, 32'h8);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_CLR, 32'h2);
    rd(A_STAT, d); check("R5 partial clear", d, 32'hC);
    wr(A_CLR, 32'h0);
    rd(A_STAT, d); check("R5 zero bits no effect", d, 32'hC);
    wr(A_CLR, 32'hC);
    rd(A_STAT, d); check("R5 clear rest", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    irq_pin[3] = 1'b0; settle();
    irq_pin[3] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(A_CLR, 32'h8);
    rd(A_STAT, d); check("R7 edge wins over clear", d & 32'h8, 32'h8);
    wr(A_CLR, 32'h8);
    rd(A_STAT, d); check("R5 later clear works", d & 32'h8, 32'h0);
  endtask

  task automatic t_typewr();
    logic [31:0] d;
    irq_pin[1] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(A_TYPE, 32'h5555_00E4);
    @(posedge clk); @(negedge clk);
    rd(A_STAT, d); check("R8 edge dropped on type write", d & 32'h2, 32'h0);
    irq_pin[1] = 1'b1;
    irq_pin[0] = 1'b0; settle();
    rd(A_STAT, d); check("R3 level set before mode change", d & 32'h1, 32'h1);
    wr(A_TYPE, 32'h5555_00E6);
    rd(A_STAT, d); check("R8 mode change clears flag", d & 32'h1, 32'h0);
    irq_pin[0] = 1'b1; settle();
    rd(A_STAT, d); check("R8 rising after change", d & 32'h1, 32'h1);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_latency_map();
    logic [31:0] d;
    irq_pin[2] = 1'b0; settle();
    irq_pin[2] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(A_STAT, d); check("R1 not visible after 2 edges", d & 32'h4, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(A_STAT, d); check("R1 visible after 3 edges", d & 32'h4, 32'h4);
    check("R9 irq_out mirrors status", {16'h0, irq_out}, d);
    rd(A_CLR, d); check("R9 clear offset reads zero", d, 32'h0);
    rd(8'h1C, d); check("R9 unmapped reads zero", d, 32'h0);
    wr(A_CLR, 32'h4);
    check("R9 irq_out after clear", {16'h0, irq_out}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type_rw();
    t_level();
    t_edges();
    t_clear();
    t_collide();
    t_typewr();
    t_latency_map();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule